// File: doc/BRIEF.md
# Shared-Prescaler Timer/Counter with Watchdog

This block pairs an 8-bit up-counter with a watchdog. Both use one power-of-two prescaler, and a configuration bit hands that prescaler to one of them. The instruction cycle is the oscillator clock divided by four. In timer mode the counter counts instruction cycles. In counter mode it counts edges of an external input, sampled once per instruction cycle, and a configuration bit chooses rising or falling edges. When the counter wraps from 255 to 0 it sets a sticky flag. The interrupt output is that flag gated by an enable bit.

The watchdog advances on a separate tick input that is already synchronous to the oscillator clock. It counts a base number of ticks, scaled by the prescaler when the prescaler is assigned to it. If no clear strobe arrives first, it emits a one-cycle reset request and starts over. Software loads the counter through a write port. A load restarts the prescaler and holds off counting for two instruction cycles.

Configuration word `cfg_i`: bits [2:0] ratio code k, bit 3 prescaler owner (0 = counter, 1 = watchdog), bit 4 count source (0 = instruction cycles, 1 = external pin), bit 5 edge polarity (0 = rising, 1 = falling), bit 6 interrupt enable.

Top module: `tc_timer_wdt`

## Requirements
- R1: After synchronous reset, the count, the flag, the interrupt and the reset request are all 0.
- R2: With the prescaler owned by the watchdog and the count source internal, the count rises by one once every 4 clock cycles.
- R3: With the prescaler owned by the counter, the count rises once per 2^(k+1) counting events, so ratios run from 1:2 (k=0) to 1:256 (k=7).
- R4: With the count source external, each rising edge of `ext_pin_i` (bit 5 = 0) or each falling edge (bit 5 = 1) is counted once. The pin is sampled at instruction-cycle boundaries through two stages.
- R5: A write loads `cnt_wdata_i` into the count on the next edge and clears the prescaler. The next two instruction-cycle boundaries then do not advance the count or the prescaler, and a write wins over an increment in the same cycle.
- R6: A wrap from 255 to 0 sets the flag whatever bit 6 holds. `flag_clr_i` clears the flag, and a wrap in the same cycle wins over the clear.
- R7: `irq_o` is high exactly when the flag is set and bit 6 is 1.
- R8: With the prescaler owned by the counter, the watchdog raises `wdt_rst_o` for one cycle after WDT_BASE ticks without a clear, then restarts its count.
- R9: With the prescaler owned by the watchdog, the timeout is WDT_BASE × 2^k ticks (ratio 1:1 for k=0 up to 1:128).
- R10: `wdt_clr_i` restarts the watchdog count, clears the prescaler when the watchdog owns it, and suppresses a reset request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_i | input | 7 | Configuration word (fields above) |
| cnt_we_i | input | 1 | Count load strobe |
| cnt_wdata_i | input | 8 | Count load value |
| cnt_q_o | output | 8 | Current count |
| ext_pin_i | input | 1 | External count input |
| wdt_tick_i | input | 1 | Watchdog time-base tick, one clock wide |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| flag_clr_i | input | 1 | Wrap flag clear strobe |
| flag_o | output | 1 | Wrap flag |
| irq_o | output | 1 | Gated interrupt request |
| wdt_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The assertions assume that `wdt_tick_i` and all strobes are single-clock pulses synchronous to `clk`. They also assume that `cfg_i` changes only between counting events and never in a cycle that matters to the property being checked. The stimulus changes inputs only at falling clock edges and raises each strobe for exactly one cycle. It drives the tick as a regular pulse train and toggles the external pin slowly enough that every level is sampled by at least two instruction-cycle boundaries.

// File: rtl/tc_pkg.sv
// Shared configuration layout for the timer/watchdog block.
// Assumes the configuration word is held stable by its owner between uses.
package tc_pkg;
    localparam int CFG_W   = 7;
    localparam int RSEL_W  = 3;

    typedef struct packed {
        logic              irq_en;   // gate for the interrupt output
        logic              fall;     // external edge polarity
        logic              ext_src;  // count external edges
        logic              ps_wdt;   // prescaler owned by watchdog
        logic [RSEL_W-1:0] ratio;    // power-of-two ratio code
    } tc_cfg_t;
endpackage

// File: rtl/tc_clk_front.sv
// Instruction-cycle generator and external edge detector.
// Produces a one-clock strobe per instruction cycle and a counting event
// that is either that strobe or a synchronized edge of the external pin.
// Assumes the pin holds each level across at least two instruction cycles.
module tc_clk_front #(
    parameter int INSN_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin_i,
    input  logic ext_sel_i,
    input  logic fall_sel_i,
    output logic icyc_o,
    output logic src_evt_o
);
    localparam int PH_W = (INSN_DIV > 1) ? $clog2(INSN_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INSN_DIV - 1);

    logic [PH_W-1:0] phase_q;
    logic            samp_a_q;
    logic            samp_b_q;
    logic            edge_seen;

    // Free-running oscillator phase within the instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase_q <= '0;
        else if (phase_q == PH_LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    assign icyc_o = (phase_q == PH_LAST);

    // Two-stage sampling of the external pin at instruction boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_a_q <= 1'b0;
            samp_b_q <= 1'b0;
        end else if (icyc_o) begin
            samp_b_q <= samp_a_q;
            samp_a_q <= ext_pin_i;
        end
    end

    // Edge of the selected polarity between the two samples.
    always_comb begin
        edge_seen = fall_sel_i ? (~samp_a_q & samp_b_q) : (samp_a_q & ~samp_b_q);
        src_evt_o = icyc_o & (ext_sel_i ? edge_seen : 1'b1);
    end

    a_r2_icyc_single: assert property (@(posedge clk) disable iff (!rst_n)
        icyc_o |=> !icyc_o);
    a_r4_evt_on_icyc: assert property (@(posedge clk) disable iff (!rst_n)
        src_evt_o |-> icyc_o);
endmodule

// File: rtl/tc_prescaler.sv
// Shared power-of-two prescaler. The owner input picks whether it divides
// counting events (ratio 2^(k+1)) or watchdog ticks (ratio 2^k); the other
// path passes straight through at 1:1.
// Assumes clear and the owned event may coincide; clear wins.
module tc_prescaler #(
    parameter int RSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_evt_i,
    input  logic              wdt_tick_i,
    input  logic              own_wdt_i,
    input  logic [RSEL_W-1:0] ratio_i,
    input  logic              clr_i,
    output logic              tmr_step_o,
    output logic              wdt_step_o
);
    localparam int PS_W = 1 << RSEL_W;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] tmr_mask;
    logic [PS_W-1:0] wdt_mask;
    logic            tmr_hit;
    logic            wdt_hit;
    logic            adv;

    // Terminal-count masks for both ratio tables.
    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            tmr_mask[i] = (i <= int'(ratio_i));
            wdt_mask[i] = (i <  int'(ratio_i));
        end
        tmr_hit = ((ps_q & tmr_mask) == tmr_mask);
        wdt_hit = ((ps_q & wdt_mask) == wdt_mask);
        adv     = own_wdt_i ? wdt_tick_i : tmr_evt_i;
        tmr_step_o = own_wdt_i ? tmr_evt_i : (tmr_evt_i & tmr_hit);
        wdt_step_o = own_wdt_i ? (wdt_tick_i & wdt_hit) : wdt_tick_i;
    end

    // Prescaler count: restart on clear, else advance on the owned event.
    always_ff @(posedge clk) begin
        if (!rst_n)   ps_q <= '0;
        else if (clr_i) ps_q <= '0;
        else if (adv)   ps_q <= ps_q + 1'b1;
    end

    a_r3_step_needs_evt: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_step_o |-> tmr_evt_i);
    a_r9_wstep_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_step_o |-> wdt_tick_i);
endmodule

// File: rtl/tc_timer8.sv
// Loadable up-counter with wrap flag and post-load hold-off.
// A load sets a hold that blocks the next HOLD_CYC instruction boundaries.
// Assumes step_i is already gated by ready_o in the parent.
module tc_timer8 #(
    parameter int CNT_W    = 8,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             icyc_i,
    input  logic             step_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             ready_o
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [HOLD_W-1:0] hold_q;
    logic              flag_q;
    logic              wrap;

    assign wrap    = step_i & ~we_i & (cnt_q == {CNT_W{1'b1}});
    assign ready_o = (hold_q == '0);
    assign cnt_o   = cnt_q;
    assign flag_o  = flag_q;

    // Count register: a load wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (we_i)   cnt_q <= wdata_i;
        else if (step_i) cnt_q <= cnt_q + 1'b1;
    end

    // Hold-off after a load, consumed one instruction boundary at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hold_q <= '0;
        else if (we_i)                    hold_q <= HOLD_W'(HOLD_CYC);
        else if (icyc_i && hold_q != '0)  hold_q <= hold_q - 1'b1;
    end

    // Sticky wrap flag: setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (wrap)       flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    a_r6_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);
    a_r5_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0) |-> !step_i);
    a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/tc_watchdog.sv
// Watchdog counter: counts prescaled ticks and pulses a reset request for
// one cycle when BASE steps pass without a clear, then starts over.
// Assumes step_i is a single-cycle pulse.
module tc_watchdog #(
    parameter int BASE = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clr_i,
    output logic rst_req_o
);
    localparam int WC_W = (BASE > 1) ? $clog2(BASE) : 1;
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(BASE - 1);

    logic [WC_W-1:0] wcnt_q;
    logic            req_q;

    // Timeout count and registered reset request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            req_q  <= 1'b0;
        end else if (clr_i) begin
            wcnt_q <= '0;
            req_q  <= 1'b0;
        end else if (step_i) begin
            if (wcnt_q == WC_LAST) begin
                wcnt_q <= '0;
                req_q  <= 1'b1;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
                req_q  <= 1'b0;
            end
        end else begin
            req_q <= 1'b0;
        end
    end

    assign rst_req_o = req_q;

    a_r10_clear_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !rst_req_o);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/tc_timer_wdt.sv
// Top: 8-bit timer/counter and watchdog sharing one prescaler.
// Assumes all strobes and the watchdog tick are clk-synchronous pulses.
module tc_timer_wdt #(
    parameter int CNT_W    = 8,
    parameter int INSN_DIV = 4,
    parameter int WDT_BASE = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [tc_pkg::CFG_W-1:0] cfg_i,
    input  logic                   cnt_we_i,
    input  logic [CNT_W-1:0]       cnt_wdata_i,
    output logic [CNT_W-1:0]       cnt_q_o,
    input  logic                   ext_pin_i,
    input  logic                   wdt_tick_i,
    input  logic                   wdt_clr_i,
    input  logic                   flag_clr_i,
    output logic                   flag_o,
    output logic                   irq_o,
    output logic                   wdt_rst_o
);
    import tc_pkg::*;

    tc_cfg_t cfg;
    logic    icyc;
    logic    src_evt;
    logic    ready;
    logic    tmr_evt;
    logic    tmr_step;
    logic    wdt_step;
    logic    ps_clr;

    assign cfg     = tc_cfg_t'(cfg_i);
    assign tmr_evt = src_evt & ready;
    assign ps_clr  = cnt_we_i | (wdt_clr_i & cfg.ps_wdt);
    assign irq_o   = flag_o & cfg.irq_en;

    tc_clk_front #(.INSN_DIV(INSN_DIV)) front_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin_i  (ext_pin_i),
        .ext_sel_i  (cfg.ext_src),
        .fall_sel_i (cfg.fall),
        .icyc_o     (icyc),
        .src_evt_o  (src_evt)
    );

    tc_prescaler #(.RSEL_W(RSEL_W)) ps_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_evt_i  (tmr_evt),
        .wdt_tick_i (wdt_tick_i),
        .own_wdt_i  (cfg.ps_wdt),
        .ratio_i    (cfg.ratio),
        .clr_i      (ps_clr),
        .tmr_step_o (tmr_step),
        .wdt_step_o (wdt_step)
    );

    tc_timer8 #(.CNT_W(CNT_W), .HOLD_CYC(2)) tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .icyc_i     (icyc),
        .step_i     (tmr_step),
        .we_i       (cnt_we_i),
        .wdata_i    (cnt_wdata_i),
        .flag_clr_i (flag_clr_i),
        .cnt_o      (cnt_q_o),
        .flag_o     (flag_o),
        .ready_o    (ready)
    );

    tc_watchdog #(.BASE(WDT_BASE)) wdt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (wdt_step),
        .clr_i     (wdt_clr_i),
        .rst_req_o (wdt_rst_o)
    );

    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (cnt_q_o == '0 && !flag_o && !wdt_rst_o));
endmodule

// File: tb/tc_timer_wdt_tb.sv
module tc_timer_wdt_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_i = 7'b0001000;
    logic       cnt_we_i = 1'b0;
    logic [7:0] cnt_wdata_i = 8'd0;
    logic [7:0] cnt_q_o;
    logic       ext_pin_i = 1'b0;
    logic       wdt_tick_i = 1'b0;
    logic       wdt_clr_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic       flag_o, irq_o, wdt_rst_o;

    localparam int BASE = 18;

    tc_timer_wdt #(.WDT_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .cnt_we_i(cnt_we_i),
        .cnt_wdata_i(cnt_wdata_i), .cnt_q_o(cnt_q_o), .ext_pin_i(ext_pin_i),
        .wdt_tick_i(wdt_tick_i), .wdt_clr_i(wdt_clr_i), .flag_clr_i(flag_clr_i),
        .flag_o(flag_o), .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, pulses = 0;
    int tick_ctr = 0, pin_ctr = 0;
    bit tick_en = 0, pin_en = 0, finished = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    int m_ph, m_sa, m_sb, m_ps, m_cnt, m_hold, m_flag, m_wcnt, m_rst;

    always @(posedge clk) begin
        bit ic, edge_ok, evt, gated, tstep, wstep, adv_ps;
        int k;
        if (!rst_n) begin
            m_ph = 0; m_sa = 0; m_sb = 0; m_ps = 0; m_cnt = 0;
            m_hold = 0; m_flag = 0; m_wcnt = 0; m_rst = 0;
        end else begin
            ic = (m_ph == 3);
            edge_ok = cfg_i[5] ? (m_sa == 0 && m_sb == 1) : (m_sa == 1 && m_sb == 0);
            evt = ic && (cfg_i[4] ? edge_ok : 1'b1);
            gated = evt && (m_hold == 0);
            k = int'(cfg_i[2:0]);
            if (!cfg_i[3]) begin
                tstep = gated && (((m_ps + 1) % (2 << k)) == 0);
                wstep = wdt_tick_i;
                adv_ps = gated;
            end else begin
                tstep = gated;
                wstep = wdt_tick_i && (((m_ps + 1) % (1 << k)) == 0);
                adv_ps = wdt_tick_i;
            end
            // flag
            if (tstep && !cnt_we_i && m_cnt == 255) m_flag = 1;
            else if (flag_clr_i) m_flag = 0;
            // prescaler
            if (cnt_we_i || (wdt_clr_i && cfg_i[3])) m_ps = 0;
            else if (adv_ps) m_ps = (m_ps + 1) % 256;
            // count and hold
            if (cnt_we_i) m_cnt = int'(cnt_wdata_i);
            else if (tstep) m_cnt = (m_cnt + 1) % 256;
            if (cnt_we_i) m_hold = 2;
            else if (ic && m_hold > 0) m_hold = m_hold - 1;
            // watchdog
            if (wdt_clr_i) begin m_wcnt = 0; m_rst = 0; end
            else if (wstep) begin
                if (m_wcnt == BASE - 1) begin m_wcnt = 0; m_rst = 1; end
                else begin m_wcnt = m_wcnt + 1; m_rst = 0; end
            end else m_rst = 0;
            // sampler and phase
            if (ic) begin m_sb = m_sa; m_sa = int'(ext_pin_i); end
            m_ph = (m_ph + 1) % 4;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: compare against the model, then update free-running stimulus.
    task automatic step();
        @(negedge clk);
        if (rst_n) begin
            chk(cur_req, "count", int'(cnt_q_o), m_cnt);
            chk(cur_req, "flag", int'(flag_o), m_flag);
            chk(cur_req, "irq", int'(irq_o), (m_flag != 0 && cfg_i[6]) ? 1 : 0);
            chk(cur_req, "wdt_rst", int'(wdt_rst_o), m_rst);
        end
        if (wdt_rst_o) pulses++;
        cnt_we_i = 1'b0; flag_clr_i = 1'b0; wdt_clr_i = 1'b0;
        if (tick_en) begin tick_ctr++; wdt_tick_i = (tick_ctr % 3 == 0); end
        else wdt_tick_i = 1'b0;
        if (pin_en) begin pin_ctr++; if (pin_ctr % 12 == 0) ext_pin_i = ~ext_pin_i; end
    endtask

    task automatic load(input int v);
        cnt_wdata_i = 8'(v); cnt_we_i = 1'b1; step();
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Watchdog on the run itself.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        run(3);
        cur_req = "R1";
        chk("R1", "count", int'(cnt_q_o), 0);
        chk("R1", "flag", int'(flag_o), 0);
        chk("R1", "wdt_rst", int'(wdt_rst_o), 0);
        rst_n = 1'b1;
        run(1);

        cur_req = "R2"; cfg_i = 7'b0001000; load(0); run(80);
        chk("R2", "count after 81 clocks", int'(cnt_q_o), m_cnt);

        cur_req = "R3"; cfg_i = 7'b0000010; load(0); run(200);
        cfg_i = 7'b0000111; load(0); run(2200);
        chk("R3", "1:256 count", int'(cnt_q_o), m_cnt);

        cur_req = "R4"; cfg_i = 7'b0011000; pin_en = 1; load(0); run(300);
        cfg_i = 7'b0111000; run(300); pin_en = 0;

        cur_req = "R5"; cfg_i = 7'b0001000;
        for (int i = 0; i < 6; i++) begin run(i); load(10 * i + 3); run(14); end
        cfg_i = 7'b0000001; load(7); run(40);

        cur_req = "R6"; cfg_i = 7'b0001000; load(250); run(40);
        chk("R6", "flag after wrap", int'(flag_o), 1);
        cur_req = "R7";
        chk("R7", "irq while disabled", int'(irq_o), 0);
        cfg_i = 7'b1001000; run(1);
        chk("R7", "irq when enabled", int'(irq_o), 1);
        cur_req = "R6"; flag_clr_i = 1'b1; run(1);
        chk("R6", "flag after clear", int'(flag_o), 0);

        cur_req = "R8"; cfg_i = 7'b0000000; tick_en = 1; wdt_clr_i = 1'b1; run(1);
        pulses = 0; run(200);
        chk("R8", "pulse seen", (pulses > 0) ? 1 : 0, 1);

        cur_req = "R10"; pulses = 0;
        for (int i = 0; i < 10; i++) begin wdt_clr_i = 1'b1; run(30); end
        chk("R10", "pulses with clears", pulses, 0);

        cur_req = "R9"; cfg_i = 7'b0001011; wdt_clr_i = 1'b1; run(1);
        pulses = 0; run(1000);
        chk("R9", "pulse seen 1:8", (pulses > 0) ? 1 : 0, 1);
        tick_en = 0; run(4);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule